// File: doc/BRIEF.md
# Instruction Space Tunneling Generator

This block feeds a hardware fuzzing harness with candidate instruction byte strings of up to fifteen bytes. It keeps one candidate buffer, starting from all zeros, and a marker that points at the byte being enumerated. Each candidate goes out on a valid/ready stream. An external length probe then returns the number of bytes the decoder actually consumed. That length decides which byte is enumerated next. When the length changes, the marker jumps to the last byte of the new instruction. When it does not change, the same byte keeps counting. When the marked byte is at 0xFF, it wraps and the carry walks toward byte 0. Bytes that do not alter decoding are therefore skipped, and the bytes that do are searched exhaustively.

Only one candidate is outstanding at a time. The candidate stream obeys the usual back-pressure rule: once `cand_valid` is high, the bytes stay frozen until a cycle with `cand_ready` high accepts them. After acceptance the block raises `len_ready` and waits for exactly one length response. The next candidate is computed on the clock edge that accepts the response and appears one cycle later. A carry that runs past byte 0 ends the search and raises `done`. A zero length raises `err`. Both are terminal until reset.

Top module: `tunnel_gen`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the first cycle with `rst_n` high shows `cand_valid`=1, `cand_bytes` all zero, `len_ready`=0, `done`=0 and `err`=0.
- R2: While `cand_valid` is high and `cand_ready` is low, `cand_valid` stays high and `cand_bytes` does not change.
- R3: On the first response after reset, or on a length L that differs from the previous accepted length, the next candidate increments byte L-1 (byte i sits at `cand_bytes[8i+7:8i]`, byte 0 first), keeps the lower bytes and clears every byte above L-1.
- R4: When the accepted length equals the previous one, the next candidate increments the same marked byte again.
- R5: If the byte to be incremented is 0xFF, it wraps to 0x00 and the increment moves to the nearest lower byte that is not 0xFF. Every byte above the incremented one becomes zero, and the marker rests on the incremented byte.
- R6: After a candidate is accepted, `cand_valid` is low and `len_ready` is high until one response is accepted. `len_valid` presented while `len_ready` is low has no effect on the candidate sequence.
- R7: When the carry would pass below byte 0, `done` rises the cycle after the response is accepted and stays high. `cand_valid` stays low and no further candidate is produced until reset.
- R8: An accepted length of 0 (or above 15) raises `err` the next cycle and holds it. `cand_valid` and `len_ready` stay low from then on, and `done` stays low.
- R9: A length of 15 is valid and places the marker on byte 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cand_valid | output | 1 | Candidate available |
| cand_ready | input | 1 | Harness accepts the candidate |
| cand_bytes | output | 120 | Candidate bytes, byte 0 in bits 7:0 |
| len_valid | input | 1 | Length response present |
| len_ready | output | 1 | Block waits for a length response |
| len_value | input | 4 | Observed instruction length in bytes |
| done | output | 1 | Search exhausted |
| err | output | 1 | Invalid length received |

## Verification
Four length-probe behaviours are applied. The first is a constant length of one. It tells a plain single-byte count through 0xFF from an early or late end of the search. The second probe grows the instruction from two to three bytes for a single value of byte 1. It separates the marker jump on a longer length, the single-level carry, the clearing of tail bytes when the length shrinks, and the same-length increment. The third makes byte 1 at 0xFF yield a three-byte instruction. Its carry must cross two 0xFF bytes at once before the search collapses to byte 0 and finishes. The fourth returns fifteen twice and then zero. It separates the top-byte marker and the same-length step from the error stop. Random stalls on both handshakes, plus stray length responses outside the waiting window, run throughout and show that back-pressure and ignored inputs leave the sequence intact.

// File: rtl/tunnel_pkg.sv
package tunnel_pkg;

  typedef enum logic [1:0] {
    TG_EMIT = 2'd0,
    TG_WAIT = 2'd1,
    TG_DONE = 2'd2,
    TG_ERR  = 2'd3
  } tg_state_e;

  localparam int unsigned TG_BYTE_W = 8;
  localparam logic [TG_BYTE_W-1:0] TG_BYTE_MAX = 8'hFF;

endpackage

// File: rtl/tunnel_seek.sv
// Finds the highest byte at or below the start index that can still be
// incremented without wrapping.
module tunnel_seek
  import tunnel_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 15,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [NUM_BYTES*TG_BYTE_W-1:0] bytes_in,
  input  logic [IDX_W-1:0]               start_idx,
  output logic                           found,
  output logic [IDX_W-1:0]               pos
);

  logic [NUM_BYTES-1:0] open_slot;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
    assign open_slot[g] = (bytes_in[g*TG_BYTE_W +: TG_BYTE_W] != TG_BYTE_MAX)
                          && (IDX_W'(g) <= start_idx);
  end

  always_comb begin
    found = |open_slot;
    pos   = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (open_slot[i]) pos = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tunnel_update.sv
// Builds the next candidate: keep bytes below pos, bump pos, clear above.
module tunnel_update
  import tunnel_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 15,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [NUM_BYTES*TG_BYTE_W-1:0] bytes_in,
  input  logic [IDX_W-1:0]               pos,
  output logic [NUM_BYTES*TG_BYTE_W-1:0] bytes_out
);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic [TG_BYTE_W-1:0] cur;
    assign cur = bytes_in[g*TG_BYTE_W +: TG_BYTE_W];
    always_comb begin
      if (IDX_W'(g) < pos)       bytes_out[g*TG_BYTE_W +: TG_BYTE_W] = cur;
      else if (IDX_W'(g) == pos) bytes_out[g*TG_BYTE_W +: TG_BYTE_W] = cur + 8'd1;
      else                       bytes_out[g*TG_BYTE_W +: TG_BYTE_W] = '0;
    end
  end

endmodule

// File: rtl/tunnel_ctrl.sv
// Handshake sequencing: emit one candidate, wait for one length, repeat.
module tunnel_ctrl
  import tunnel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cand_ready,
  input  logic len_valid,
  input  logic len_bad,
  input  logic can_step,
  output logic cand_valid,
  output logic len_ready,
  output logic done,
  output logic err,
  output logic advance
);

  tg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TG_EMIT: if (cand_ready) state_d = TG_WAIT;
      TG_WAIT: begin
        if (len_valid) begin
          if (len_bad)       state_d = TG_ERR;
          else if (!can_step) state_d = TG_DONE;
          else               state_d = TG_EMIT;
        end
      end
      TG_DONE: state_d = TG_DONE;
      TG_ERR:  state_d = TG_ERR;
      default: state_d = TG_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= TG_EMIT;
    else        state_q <= state_d;
  end

  assign cand_valid = (state_q == TG_EMIT);
  assign len_ready  = (state_q == TG_WAIT);
  assign done       = (state_q == TG_DONE);
  assign err        = (state_q == TG_ERR);
  assign advance    = len_ready && len_valid && !len_bad && can_step;

endmodule

// File: rtl/tunnel_gen.sv
module tunnel_gen
  import tunnel_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 15,
  parameter int unsigned LEN_W     = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  output logic                           cand_valid,
  input  logic                           cand_ready,
  output logic [NUM_BYTES*TG_BYTE_W-1:0] cand_bytes,
  input  logic                           len_valid,
  output logic                           len_ready,
  input  logic [LEN_W-1:0]               len_value,
  output logic                           done,
  output logic                           err
);

  localparam int unsigned IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int unsigned BUF_W = NUM_BYTES * TG_BYTE_W;

  logic [BUF_W-1:0] cand_q, cand_d;
  logic [IDX_W-1:0] mark_q, start_idx, hit_idx;
  logic [LEN_W-1:0] prev_q, len_m1;
  logic [31:0]      len_ext;
  logic             len_bad, hit, advance, len_changed;

  assign len_ext     = 32'(len_value);
  assign len_bad     = (len_ext == 32'd0) || (len_ext > NUM_BYTES);
  assign len_m1      = len_value - LEN_W'(1);
  assign len_changed = (prev_q == '0) || (prev_q != len_value);
  assign start_idx   = len_changed ? IDX_W'(len_m1) : mark_q;

  tunnel_seek #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_seek (
    .bytes_in  (cand_q),
    .start_idx (start_idx),
    .found     (hit),
    .pos       (hit_idx)
  );

  tunnel_update #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_update (
    .bytes_in  (cand_q),
    .pos       (hit_idx),
    .bytes_out (cand_d)
  );

  tunnel_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_ready (cand_ready),
    .len_valid  (len_valid),
    .len_bad    (len_bad),
    .can_step   (hit),
    .cand_valid (cand_valid),
    .len_ready  (len_ready),
    .done       (done),
    .err        (err),
    .advance    (advance)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= '0;
      mark_q <= '0;
      prev_q <= '0;
    end else if (advance) begin
      cand_q <= cand_d;
      mark_q <= hit_idx;
      prev_q <= len_value;
    end
  end

  assign cand_bytes = cand_q;

endmodule

// File: rtl/tunnel_gen_chk.sv
module tunnel_gen_chk #(
  parameter int unsigned NUM_BYTES = 15,
  parameter int unsigned LEN_W     = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cand_valid,
  input logic                   cand_ready,
  input logic [NUM_BYTES*8-1:0] cand_bytes,
  input logic                   len_valid,
  input logic                   len_ready,
  input logic [LEN_W-1:0]       len_value,
  input logic                   done,
  input logic                   err
);

  AST_HOLD_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_bytes)); // R2

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(cand_valid && len_ready)); // R6

  AST_WAIT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_ready |=> len_ready && !cand_valid); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !cand_valid && !len_ready); // R7

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    len_valid && len_ready && (len_value == '0) |=> err); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && !done && !cand_valid && !len_ready); // R8

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cand_valid, len_ready, done, err})); // R6

endmodule

bind tunnel_gen tunnel_gen_chk #(.NUM_BYTES(NUM_BYTES), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/tunnel_gen_tb.sv
module tunnel_gen_tb;

  localparam int NB = 15;
  localparam int BW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cand_ready = 1'b0;
  logic          len_valid = 1'b0;
  logic [3:0]    len_value = '0;
  logic          cand_valid, len_ready, done, err;
  logic [BW-1:0] cand_bytes;

  always #4 clk = ~clk;

  tunnel_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_bytes(cand_bytes), .len_valid(len_valid), .len_ready(len_ready),
    .len_value(len_value), .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;

  logic [BW-1:0] exp_q[$];
  string         tag_q[$];

  logic [BW-1:0] m_buf;
  int            m_mark;
  int            m_prev;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [BW-1:0] b, input int i);
    return b[8*i +: 8];
  endfunction

  function automatic int lenfn(input int sel, input logic [BW-1:0] b, input int resp);
    case (sel)
      0: return 1;
      1: return (byte_of(b, 0) == 8'h00) ? ((byte_of(b, 1) == 8'h05) ? 3 : 2) : 1;
      2: return (resp < 2) ? 15 : 0;
      default: return (byte_of(b, 0) != 8'h00) ? 1 : ((byte_of(b, 1) == 8'hFF) ? 3 : 2);
    endcase
  endfunction

  // Reference step taken from the requirements (R3, R4, R5, R9).
  task automatic model_step(input int L, output bit exhausted);
    int    start;
    int    j;
    bit    changed;
    string tag;
    changed = (m_prev == 0) || (L != m_prev);
    start   = changed ? L - 1 : m_mark;
    j = -1;
    for (int i = start; i >= 0; i--) begin
      if (byte_of(m_buf, i) != 8'hFF) begin j = i; break; end
    end
    exhausted = (j < 0);
    if (!exhausted) begin
      for (int i = 0; i < NB; i++) begin
        if (i == j)     m_buf[8*i +: 8] = byte_of(m_buf, i) + 8'd1;
        else if (i > j) m_buf[8*i +: 8] = 8'h00;
      end
      if (j < start)       tag = "R5";
      else if (L == NB)    tag = "R9";
      else if (changed)    tag = "R3";
      else                 tag = "R4";
      m_mark = j;
      m_prev = L;
      exp_q.push_back(m_buf);
      tag_q.push_back(tag);
    end
  endtask

  // Monitor: compares every accepted candidate against the scoreboard.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && cand_valid && cand_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected candidate", 128'(cand_bytes), 128'd0);
      end else begin
        logic [BW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cand_bytes == e, t, "candidate bytes", 128'(cand_bytes), 128'(e));
      end
    end
  end

  task automatic reset_dut();
    rst_n = 1'b0; cand_ready = 1'b0; len_valid = 1'b0; len_value = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cand_valid == 1'b1, "R1", "cand_valid after reset", 128'(cand_valid), 128'd1);
    check(cand_bytes == '0, "R1", "cand_bytes after reset", 128'(cand_bytes), 128'd0);
    check({len_ready, done, err} == 3'b000, "R1", "len_ready/done/err after reset",
          128'({len_ready, done, err}), 128'd0);
  endtask

  task automatic run(input int sel);
    int            resp;
    int            L;
    bit            fin;
    bit            held;
    bit            ex;
    logic [BW-1:0] hold;
    reset_dut();
    m_buf = '0; m_mark = 0; m_prev = 0;
    exp_q.delete(); tag_q.delete();
    exp_q.push_back('0); tag_q.push_back("R1");
    resp = 0; fin = 1'b0;
    while (!fin) begin
      held = 1'b0;
      do begin
        @(negedge clk);
        if (held)
          check(cand_valid && (cand_bytes == hold), "R2", "stalled candidate",
                128'(cand_bytes), 128'(hold));
        cand_ready = ($urandom_range(0, 3) != 0);
        len_valid  = 1'($urandom_range(0, 1));  // stray responses, R6
        len_value  = 4'($urandom_range(0, 15));
        held = cand_valid && !cand_ready;
        hold = cand_bytes;
      end while (!(cand_valid && cand_ready));
      @(negedge clk);
      cand_ready = 1'b0; len_valid = 1'b0;
      check(len_ready && !cand_valid, "R6", "waiting for length",
            128'({len_ready, cand_valid}), 128'b10);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      L = lenfn(sel, m_buf, resp);
      resp++;
      len_valid = 1'b1; len_value = 4'(L);
      @(negedge clk);
      len_valid = 1'b0;
      if (L == 0) begin
        repeat (3) begin
          check(err && !cand_valid && !len_ready && !done, "R8", "error stop",
                128'({err, cand_valid, len_ready, done}), 128'b1000);
          @(negedge clk);
        end
        fin = 1'b1;
      end else begin
        model_step(L, ex);
        if (ex) begin
          repeat (3) begin
            cand_ready = 1'b1;
            check(done && !cand_valid && !err, "R7", "search exhausted",
                  128'({done, cand_valid, err}), 128'b100);
            @(negedge clk);
          end
          cand_ready = 1'b0;
          fin = 1'b1;
        end
      end
    end
    check(exp_q.size() == 0, "R7", "leftover expected candidates",
          128'(exp_q.size()), 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run(0);
    run(1);
    run(3);
    run(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule